// File: doc/BRIEF.md
# HyperBus Pseudo-Static RAM Controller

This block lets a simple host port read and write 16-bit words in an 8-bit HyperBus pseudo-static RAM. The host posts one request at a time with `req_valid`/`req_ready`, giving a word address, a direction and write data. The controller then runs one complete bus transaction and returns read data on a one-cycle response strobe. A transaction has four parts: a 48-bit command-address phase, an initial latency wait, one word moved as two double-data-rate bytes, and a recovery gap with chip select high.

The bus is modelled at double-data-rate granularity. Each cycle of `clk` is one half of the bus clock, so one byte moves per `clk` cycle and the differential clock pair toggles every cycle while chip select is low. The initial latency and the recovery gap are set at run time. Read data can be sampled a fixed number of cycles after the latency, or on transitions of the read-write data strobe driven by the memory, selected by `cfg_strobe_rd`. All configuration inputs are sampled when a request is accepted. The bidirectional lines appear as separate input, output and output-enable ports, for pad logic outside the block.

Top module: `hbus_ram_ctrl`

## Requirements
- R1: After reset and whenever no transaction is in progress, `req_ready` is high, `hb_cs_n` is high, `hb_ck_p` is low, `hb_ck_n` is high, and both output enables are low. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- R2: The command-address word goes out as six bytes in six consecutive cycles, starting in the cycle after acceptance, most significant byte first. Bit 47 is 1 for a read and 0 for a write, bit 46 is 0, and bit 45 is 1. Bits 44:16 carry word address bits above bit 2, bits 15:3 are zero, and bits 2:0 carry address bits 2:0.
- R3: With `hb_rwds_in` low throughout the command-address phase, 2*max(L,1) cycles pass between the last command-address byte and the first data byte, where L is `cfg_latency`.
- R4: When `hb_rwds_in` is high in any command-address cycle, the wait becomes 4*max(L,1) cycles.
- R5: A write drives two data cycles with `hb_dq_oe` high, upper byte first, with `hb_rwds_oe` high and `hb_rwds_out` low in both cycles.
- R6: In counted read mode (`cfg_strobe_rd`=0), the bytes on `hb_dq_in` in the two cycles right after the latency are taken as upper byte then lower byte. No strobe is needed, and chip select rises after them.
- R7: In strobe read mode (`cfg_strobe_rd`=1), every change of `hb_rwds_in` after the latency captures the byte present in that cycle: first the upper byte, then the lower byte. Chip select stays low until both bytes are captured.
- R8: While a read is waiting for or receiving data, `hb_dq_oe` and `hb_rwds_oe` are low.
- R9: After each transaction, `hb_cs_n` stays high with `req_ready` low for max(Q,1) cycles, where Q is `cfg_recovery`. Then `req_ready` returns high.
- R10: The controller steps through idle, command-address, latency, data and recovery in that order only. A `req_valid` raised while `req_ready` is low starts no transaction.
- R11: For a read, `rsp_valid` is high for exactly one cycle, the first cycle with chip select high, and `rsp_data` then holds the word. Back-to-back reads, back-to-back writes and a read after a write each complete with the full recovery gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one half bus clock per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | Read word valid, one cycle |
| rsp_data | output | 16 | Read word |
| cfg_latency | input | LAT_W | Initial latency in bus clocks (0 treated as 1) |
| cfg_recovery | input | REC_W | Recovery gap in cycles (0 treated as 1) |
| cfg_strobe_rd | input | 1 | 1 to capture read data on strobe changes |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck_p | output | 1 | Bus clock, true side |
| hb_ck_n | output | 1 | Bus clock, complement side |
| hb_dq_out | output | 8 | Data bus drive value |
| hb_dq_oe | output | 1 | Data bus drive enable |
| hb_dq_in | input | 8 | Data bus received value |
| hb_rwds_out | output | 1 | Strobe/mask drive value |
| hb_rwds_oe | output | 1 | Strobe/mask drive enable |
| hb_rwds_in | input | 1 | Strobe/mask received value |

## Verification
A table walk mixes writes and reads with latency 0 through 4 and recovery 0 through 5. It toggles the device's latency-doubling flag and the read capture mode, so that single and double waits and both capture paths are each exercised on real data. The walk orders transactions as write-write, write-read, read-read and read-write, which separates a recovery count that is too short from one that is correct. A directed pair returns read data late with a strobe: counted mode must then capture the filler bytes, and strobe mode must capture the true word. A request raised during a busy write must leave the command word and the transaction count unchanged.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_LAT   = 3'd2,
    ST_XFER  = 3'd3,
    ST_RECOV = 3'd4
  } hb_state_t;

  localparam int CA_BYTES = 6;

  // 48-bit command-address word for a memory-space linear access
  function automatic logic [47:0] ca_word(input logic rd, input logic [31:0] waddr);
    return {rd, 1'b0, 1'b1, waddr[31:3], 13'd0, waddr[2:0]};
  endfunction

  // latency wait in half-clock cycles
  function automatic int unsigned lat_span(input int unsigned lat, input logic dbl);
    int unsigned base;
    base = (lat == 0) ? 1 : lat;
    return dbl ? base * 4 : base * 2;
  endfunction

  // recovery gap in cycles
  function automatic int unsigned rec_span(input int unsigned rec);
    return (rec == 0) ? 1 : rec;
  endfunction

  // legal state steps
  function automatic logic step_ok(input hb_state_t p, input hb_state_t c);
    if (p == c) return 1'b1;
    case (p)
      ST_IDLE:  return c == ST_CMD;
      ST_CMD:   return c == ST_LAT;
      ST_LAT:   return c == ST_XFER;
      ST_XFER:  return c == ST_RECOV;
      ST_RECOV: return c == ST_IDLE;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hbus_ca_gen.sv
module hbus_ca_gen #(
  parameter int ADDR_W = 22
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        sel,
  output logic [7:0]        byte_o
);
  localparam int SLOTS = 8;

  logic [47:0] ca;
  logic [7:0]  slot [SLOTS];

  assign ca = hbus_pkg::ca_word(rd, 32'(addr));

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < hbus_pkg::CA_BYTES) begin : g_used
      assign slot[g] = ca[47-8*g -: 8];
    end else begin : g_pad
      assign slot[g] = 8'h00;
    end
  end

  assign byte_o = slot[sel];
endmodule

// File: rtl/hbus_span_cnt.sv
module hbus_span_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] span,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + W'(1);
    else          cnt <= '0;
  end

  assign last = run && (cnt == span - W'(1));
endmodule

// File: rtl/hbus_rd_capture.sv
module hbus_rd_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        strobe_mode,
  input  logic        beat,
  input  logic [7:0]  dq_in,
  input  logic        rwds_in,
  output logic        done,
  output logic [15:0] data
);
  logic       rwds_q, got_hi;
  logic [7:0] hi_q;
  logic       edge_seen, take_hi, take_lo;

  assign edge_seen = rwds_in ^ rwds_q;
  assign take_hi   = active && (strobe_mode ? (edge_seen && !got_hi) : !beat);
  assign take_lo   = active && (strobe_mode ? (edge_seen && got_hi) : beat);
  assign done      = take_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwds_q <= 1'b0;
      got_hi <= 1'b0;
      hi_q   <= '0;
      data   <= '0;
    end else begin
      rwds_q <= rwds_in;
      if (!active || take_lo) got_hi <= 1'b0;
      else if (take_hi)       got_hi <= 1'b1;
      if (take_hi) hi_q <= dq_in;
      if (take_lo) data <= {hi_q, dq_in};
    end
  end
endmodule

// File: rtl/hbus_ram_ctrl.sv
module hbus_ram_ctrl #(
  parameter int ADDR_W = 22,
  parameter int LAT_W  = 4,
  parameter int REC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic [REC_W-1:0]  cfg_recovery,
  input  logic              cfg_strobe_rd,
  output logic              hb_cs_n,
  output logic              hb_ck_p,
  output logic              hb_ck_n,
  output logic [7:0]        hb_dq_out,
  output logic              hb_dq_oe,
  input  logic [7:0]        hb_dq_in,
  output logic              hb_rwds_out,
  output logic              hb_rwds_oe,
  input  logic              hb_rwds_in
);
  import hbus_pkg::*;

  localparam int SPAN_W = LAT_W + 2;
  localparam logic [2:0] CA_LAST = 3'(CA_BYTES - 1);

  hb_state_t         state, state_nx;
  logic [2:0]        cmd_idx;
  logic              beat, ph, dbl_q;
  logic              op_wr, strobe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic [LAT_W-1:0]  lat_q;
  logic [REC_W-1:0]  rec_q;
  logic              rsp_valid_q;
  logic [REC_W-1:0]  gap_cnt;

  // named internal events
  logic              accept, bus_active, xfer_wr, xfer_rd;
  logic              lat_last, rec_last, cap_done;
  logic [SPAN_W-1:0] lat_span_w;
  logic [REC_W-1:0]  rec_span_w;
  logic [7:0]        ca_byte;

  assign accept     = req_valid && (state == ST_IDLE);
  assign bus_active = (state == ST_CMD) || (state == ST_LAT) || (state == ST_XFER);
  assign xfer_wr    = (state == ST_XFER) && op_wr;
  assign xfer_rd    = (state == ST_XFER) && !op_wr;
  assign lat_span_w = SPAN_W'(lat_span(32'(lat_q), dbl_q));
  assign rec_span_w = REC_W'(rec_span(32'(rec_q)));

  hbus_ca_gen #(.ADDR_W(ADDR_W)) ca_i (
    .rd(!op_wr), .addr(addr_q), .sel(cmd_idx), .byte_o(ca_byte)
  );

  hbus_span_cnt #(.W(SPAN_W)) lat_cnt_i (
    .clk(clk), .rst_n(rst_n), .run(state == ST_LAT), .span(lat_span_w), .last(lat_last)
  );

  hbus_span_cnt #(.W(REC_W)) rec_cnt_i (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RECOV), .span(rec_span_w), .last(rec_last)
  );

  hbus_rd_capture cap_i (
    .clk(clk), .rst_n(rst_n), .active(xfer_rd), .strobe_mode(strobe_q), .beat(beat),
    .dq_in(hb_dq_in), .rwds_in(hb_rwds_in), .done(cap_done), .data(rsp_data)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = ST_CMD;
      ST_CMD:   if (cmd_idx == CA_LAST) state_nx = ST_LAT;
      ST_LAT:   if (lat_last) state_nx = ST_XFER;
      ST_XFER:  if (op_wr ? beat : cap_done) state_nx = ST_RECOV;
      ST_RECOV: if (rec_last) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cmd_idx     <= '0;
      beat        <= 1'b0;
      ph          <= 1'b0;
      dbl_q       <= 1'b0;
      op_wr       <= 1'b0;
      strobe_q    <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      lat_q       <= '0;
      rec_q       <= '0;
      rsp_valid_q <= 1'b0;
      gap_cnt     <= '1;
    end else begin
      state       <= state_nx;
      cmd_idx     <= (state == ST_CMD) ? cmd_idx + 3'd1 : 3'd0;
      beat        <= (state == ST_XFER) ? !beat : 1'b0;
      ph          <= bus_active ? !ph : 1'b0;
      rsp_valid_q <= xfer_rd && cap_done;
      if (hb_cs_n) gap_cnt <= (gap_cnt == '1) ? gap_cnt : gap_cnt + REC_W'(1);
      else         gap_cnt <= '0;
      if (accept) begin
        op_wr    <= req_write;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        lat_q    <= cfg_latency;
        rec_q    <= cfg_recovery;
        strobe_q <= cfg_strobe_rd;
        dbl_q    <= 1'b0;
      end else if (state == ST_CMD) begin
        dbl_q <= dbl_q | hb_rwds_in;
      end
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = rsp_valid_q;
  assign hb_cs_n     = !bus_active;
  assign hb_ck_p     = bus_active && !ph;
  assign hb_ck_n     = !hb_ck_p;
  assign hb_dq_oe    = (state == ST_CMD) || xfer_wr;
  assign hb_dq_out   = (state == ST_CMD) ? ca_byte :
                       xfer_wr ? (beat ? wdata_q[7:0] : wdata_q[15:8]) : 8'h00;
  assign hb_rwds_oe  = xfer_wr;
  assign hb_rwds_out = 1'b0;

  // R1: ready only with the bus parked
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (hb_cs_n && !hb_dq_oe && !hb_rwds_oe));

  // R2: the latency wait follows exactly six command cycles
  p_ca_six_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_LAT) |-> $past(state == ST_CMD, 6));

  // R8: no drive while the device returns read data
  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_rd |-> (!hb_dq_oe && !hb_rwds_oe));

  // R9: recovery counter ends with the port-observed gap matching the span
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_last |-> (hb_cs_n && gap_cnt == rec_span_w - REC_W'(1)));

  // R10: state steps only in order
  p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok($past(state), state));

  // R11: response only after chip select is released, only for reads
  p_rsp_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (hb_cs_n && !op_wr && $past(!hb_cs_n)));
endmodule

// File: tb/hbus_ram_ctrl_tb_top.sv
module hbus_ram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // fields: wr, dbl, strobe, lat[3:0], rec[3:0], addr[21:0], data[15:0]
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'd3, 4'd2, 22'h000005, 16'hA55A},
    {1'b1, 1'b1, 1'b0, 4'd2, 4'd3, 22'h12340A, 16'h1234},
    {1'b0, 1'b0, 1'b0, 4'd3, 4'd2, 22'h000005, 16'hA55A},
    {1'b0, 1'b0, 1'b1, 4'd4, 4'd1, 22'h12340A, 16'h1234},
    {1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 22'h3FFFFF, 16'hC3E1},
    {1'b1, 1'b0, 1'b0, 4'd1, 4'd5, 22'h000000, 16'h0F0F},
    {1'b0, 1'b1, 1'b1, 4'd2, 4'd0, 22'h3FFFFF, 16'hC3E1},
    {1'b0, 1'b1, 1'b0, 4'd1, 4'd4, 22'h000000, 16'h0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  cfg_latency = '0, cfg_recovery = '0;
  logic        cfg_strobe_rd = 1'b0;
  logic        req_ready, rsp_valid, hb_cs_n, hb_ck_p, hb_ck_n, hb_dq_oe, hb_rwds_out, hb_rwds_oe;
  logic [15:0] rsp_data;
  logic [7:0]  hb_dq_out;
  logic [7:0]  hb_dq_in = 8'hEE;
  logic        hb_rwds_in = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;

  // device model state
  bit          dev_dbl = 0;
  int          dev_T = 2, dev_delay = 0, idx = 0, starts = 0;
  logic [47:0] ca_cap = '0;
  logic [7:0]  wr_hi = '0;
  logic [15:0] wr_word = '0;
  bit          wr_ctl_ok = 0, oe_bad = 0;
  logic [15:0] mem [64];
  logic [5:0]  dev_a;

  hbus_ram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_latency(cfg_latency),
    .cfg_recovery(cfg_recovery), .cfg_strobe_rd(cfg_strobe_rd), .hb_cs_n(hb_cs_n),
    .hb_ck_p(hb_ck_p), .hb_ck_n(hb_ck_n), .hb_dq_out(hb_dq_out), .hb_dq_oe(hb_dq_oe),
    .hb_dq_in(hb_dq_in), .hb_rwds_out(hb_rwds_out), .hb_rwds_oe(hb_rwds_oe),
    .hb_rwds_in(hb_rwds_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dev_a = {ca_cap[18:16], ca_cap[2:0]};

  // memory device model, acts on falling edges
  always @(negedge clk) begin
    if (hb_cs_n) begin
      idx <= 0; hb_rwds_in <= 1'b0; hb_dq_in <= 8'hEE;
    end else begin
      idx <= idx + 1;
      hb_rwds_in <= 1'b0; hb_dq_in <= 8'hEE;
      if (idx < 6) begin
        if (idx == 0) begin starts <= starts + 1; oe_bad <= 0; wr_ctl_ok <= 1; end
        ca_cap[47-8*idx -: 8] <= hb_dq_out;
        hb_rwds_in <= dev_dbl;
      end else if (ca_cap[47]) begin
        if (hb_dq_oe || hb_rwds_oe) oe_bad <= 1;
        if (idx == 6 + dev_T + dev_delay) begin
          hb_dq_in <= mem[dev_a][15:8]; hb_rwds_in <= 1'b1;
        end else if (idx == 7 + dev_T + dev_delay) begin
          hb_dq_in <= mem[dev_a][7:0];
        end
      end else begin
        if (idx == 6 + dev_T || idx == 7 + dev_T)
          if (!(hb_dq_oe && hb_rwds_oe && !hb_rwds_out)) wr_ctl_ok <= 0;
        if (idx == 6 + dev_T) wr_hi <= hb_dq_out;
        if (idx == 7 + dev_T) begin
          wr_word <= {wr_hi, hb_dq_out};
          mem[dev_a] <= {wr_hi, hb_dq_out};
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input bit dbl, input bit strobe, input logic [3:0] lat,
                         input logic [3:0] rec, input logic [21:0] addr, input logic [15:0] data,
                         input int delay, input bit poke);
    int T, Rr, n_low, n_high, k, rsp_k, rsp_n, exp_low, s0;
    logic [15:0] got;
    logic [47:0] exp_ca;
    T  = ((lat == 0) ? 1 : int'(lat)) * (dbl ? 4 : 2);
    Rr = (rec == 0) ? 1 : int'(rec);
    cfg_latency = lat; cfg_recovery = rec; cfg_strobe_rd = strobe;
    dev_dbl = dbl; dev_T = T; dev_delay = delay;
    while (!req_ready) @(negedge clk);
    s0 = starts;
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
    n_low = 0; n_high = 0; k = 0; rsp_k = -1; rsp_n = 0; got = '0;
    while (!req_ready) begin
      if (hb_cs_n) n_high++; else n_low++;
      if (rsp_valid) begin rsp_n++; rsp_k = k; got = rsp_data; end
      @(negedge clk);
      k++;
      if (poke && k == 3) begin req_valid = 1; req_addr = ~addr; end
      else req_valid = 0;
    end
    exp_ca  = {!wr, 1'b0, 1'b1, 29'(addr >> 3), 13'd0, addr[2:0]};
    exp_low = 8 + T + ((!wr && strobe) ? delay : 0);
    check(ca_cap == exp_ca, "R2 command-address word", 64'(ca_cap), 64'(exp_ca));
    check(n_low == exp_low, dbl ? "R4 doubled latency cs low length" :
          "R3 latency cs low length", 64'(n_low), 64'(exp_low));
    check(n_high == Rr, "R9 R11 recovery gap", 64'(n_high), 64'(Rr));
    check(starts == s0 + 1, "R10 one transaction per request", 64'(starts), 64'(s0 + 1));
    if (wr) begin
      check(wr_word == data, "R5 write bytes upper first", 64'(wr_word), 64'(data));
      check(wr_ctl_ok, "R5 write drive and mask", 64'(wr_ctl_ok), 64'd1);
    end else begin
      check(got == data, strobe ? "R7 strobe read data" : "R6 counted read data",
            64'(got), 64'(data));
      check(rsp_n == 1 && rsp_k == exp_low, "R11 response pulse timing",
            64'(rsp_k), 64'(exp_low));
      check(!oe_bad, "R8 drivers released during read", 64'(oe_bad), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && hb_cs_n && !hb_ck_p && hb_ck_n, "R1 idle bus after reset",
          {60'd0, req_ready, hb_cs_n, hb_ck_p, hb_ck_n}, 64'hD);
    check(!hb_dq_oe && !hb_rwds_oe && !rsp_valid, "R1 enables low after reset",
          {61'd0, hb_dq_oe, hb_rwds_oe, rsp_valid}, 64'd0);

    // table walk: covers write-write, write-read, read-read, read-write (R11)
    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i][48], VEC[i][47], VEC[i][46], VEC[i][45:42], VEC[i][41:38],
              VEC[i][37:16], VEC[i][15:0], 0, 0);
    end

    // R6: counted mode ignores a late strobe and captures filler bytes
    run_txn(0, 0, 0, 4'd2, 4'd1, 22'h000005, 16'hEEEE, 2, 0);
    // R7: strobe mode waits for the late data
    run_txn(0, 0, 1, 4'd2, 4'd1, 22'h000005, 16'hA55A, 3, 0);
    // R10: request raised while busy is ignored
    run_txn(1, 0, 0, 4'd1, 4'd2, 22'h000011, 16'h5AA5, 0, 1);
    repeat (12) @(negedge clk);
    check(hb_cs_n && req_ready, "R10 no extra transaction after busy request",
          {62'd0, hb_cs_n, req_ready}, 64'd3);
    run_txn(0, 0, 0, 4'd1, 4'd1, 22'h000011, 16'h5AA5, 0, 0);
    // R1 idle state between transactions
    check(!hb_ck_p && hb_ck_n && !hb_dq_oe, "R1 bus parked when idle",
          {61'd0, hb_ck_p, hb_ck_n, hb_dq_oe}, 64'd2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule